// File: doc/BRIEF.md
# Memory Error Status Register Bank

This block sits beside a memory controller's datapath and keeps a record of memory error events for software. The datapath reports corrected soft errors, uncorrectable hard errors, hard errors promoted to a non-maskable bus fault, interlock timeouts, other timeout codes and internal errors. Each report is a one-cycle pulse. The bank turns these pulses into sticky status bits, a 3-bit timeout code, a level interrupt gated by per-class enables, and a latched fault with its non-maskable companion.

Software reaches eight 32-bit words through a plain register bus. Words 0 to 3 hold state. Words 4 to 7 hold nothing and always read zero. A read of word 4 acknowledges the interrupt, and a read of word 5 acknowledges the fault. Status is cleared by writing ones, so writing back a word that was just read acknowledges every event it reported. The bus has no back-pressure. Every access presented with `bus_en` high is taken at that clock edge. A read returns its data one cycle later, flagged by `rd_valid`.

Top module: `mem_err_csr`

## Requirements
- R1: After reset every word reads 0, and `mem_irq`, `mem_fault` and `nmi_fault` are 0.
- R2: A read presented at an edge returns, at the next edge, the state held before that edge, with `rd_valid` high for one cycle. Words 4, 5, 6 and 7 always read 0.
- R3: Word 1 bit 20 is the decode RAM write enable. It reads back the last value written to it. All other bits of word 1 read 0.
- R4: Word 3 bits 31 (internal), 30 (interlock), 29 (soft) and 28 (hard) are plain read/write interrupt enables. Bits 27:26 and 24:0 of word 3 read 0.
- R5: Word 0 bits 26:24 hold the timeout code. An interlock timeout pulse loads 2. A timeout pulse loads `ev_tmo_code`. The interlock pulse wins if both arrive together. Writing a 1 to any of bits 26:24 clears that bit.
- R6: Word 2 flags: a soft error sets bit 29. A soft error while bit 29 is already set also sets bit 31. A hard error sets bit 30. A forced bus error sets bits 30 and 28. Writing 1 clears a flag and writing 0 leaves it unchanged.
- R7: Word 3 bit 25 is set by an internal error pulse and is cleared by writing 1 to it.
- R8: An event arriving in the same cycle as a clearing write to its bit leaves the bit set.
- R9: `mem_irq` is high only while some class has both its status and its enable set. The classes are: internal error (bit 25), interlock (code equal to 2), soft (bit 29) and hard (bit 30 or 28). After a new event in an enabled class, `mem_irq` is high from the following cycle.
- R10: A read of word 4 drops `mem_irq` while the status stays set. The interrupt rises again on the next enabled event, or after all causes have cleared and one returns. An enabled event in the same cycle as the read keeps `mem_irq` high.
- R11: `mem_fault` latches on a hard, forced, interlock or internal error. `nmi_fault` latches on a forced error. A read of word 5 clears both, unless a matching event arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, accepted at every edge it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Word index 0 to 7 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| ev_soft | input | 1 | Corrected error pulse |
| ev_hard | input | 1 | Uncorrectable error pulse |
| ev_force | input | 1 | Hard error promoted to non-maskable bus fault pulse |
| ev_ilto | input | 1 | Interlock timeout pulse |
| ev_tmo | input | 1 | Timeout pulse carrying a code |
| ev_tmo_code | input | 3 | Code loaded with `ev_tmo` |
| ev_inter | input | 1 | Internal error pulse |
| mem_irq | output | 1 | Level memory interrupt |
| mem_fault | output | 1 | Latched memory fault |
| nmi_fault | output | 1 | Latched non-maskable fault indication |

## Verification
The hardest cases to reach are the collisions: a clearing write, or an acknowledging read of word 4 or 5, at the same edge as a fresh event for the same bit. From the ports these look like ordinary accesses, so they are easy to miss. The bench drives one combined step that presents a bus access and event pulses together, and then reads the state back. It also sweeps all sixteen enable masks against each event class, all eight timeout codes, and all sixteen write-one-to-clear masks on the flag word.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;
  localparam int DW    = 32;
  localparam int IW    = 3;
  localparam int NCLS  = 4;
  localparam int CODE_LO = 24;
  localparam int CODE_W  = 3;
  localparam logic [CODE_W-1:0] CODE_ILTO = 3'd2;
  localparam int WREN_BIT  = 20;
  localparam int FLAG_LO   = 28;
  localparam int INTER_BIT = 25;
  localparam int EN_LO     = 28;
  localparam logic [IW-1:0] IX_TMO  = 3'd0;
  localparam logic [IW-1:0] IX_CTL  = 3'd1;
  localparam logic [IW-1:0] IX_FLG  = 3'd2;
  localparam logic [IW-1:0] IX_ENA  = 3'd3;
  localparam logic [IW-1:0] IX_AIRQ = 3'd4;
  localparam logic [IW-1:0] IX_AFLT = 3'd5;
  // class order inside 4-bit vectors: [3] internal, [2] interlock, [1] soft, [0] hard
  typedef struct packed {
    logic rpt;
    logic rds;
    logic crd;
    logic frc;
  } flags_t;
endpackage

// File: rtl/mem_err_sticky.sv
module mem_err_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)));
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/mem_err_irq.sv
module mem_err_irq #(
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] status,
  input  logic [NC-1:0] enable,
  input  logic [NC-1:0] new_evt,
  input  logic          ack,
  output logic          irq
);
  logic          armed_q;
  logic [NC-1:0] cause;
  logic          fresh;

  assign cause = status & enable;
  assign fresh = |(new_evt & enable);
  assign irq   = armed_q & (|cause);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b1;
    else if (fresh)      armed_q <= 1'b1;
    else if (ack)        armed_q <= 1'b0;
    else if (~|cause)    armed_q <= 1'b1;
  end

  p_ack_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fresh) |=> !irq);
  p_irq_needs_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(status & enable)));
endmodule

// File: rtl/mem_err_csr.sv
module mem_err_csr
  import mem_err_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [IW-1:0] bus_idx,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rd_valid,
  input  logic          ev_soft,
  input  logic          ev_hard,
  input  logic          ev_force,
  input  logic          ev_ilto,
  input  logic          ev_tmo,
  input  logic [CODE_W-1:0] ev_tmo_code,
  input  logic          ev_inter,
  output logic          mem_irq,
  output logic          mem_fault,
  output logic          nmi_fault
);
  localparam int NWORD = 1 << IW;

  logic wr, rd;
  logic [CODE_W-1:0] code_q, code_clr;
  logic wren_q;
  logic [NCLS-1:0] en_q;
  flags_t flg_q, flg_set, flg_clr;
  logic [0:0] inter_q;
  logic [1:0] flt_q, flt_set, flt_clr;
  logic [NCLS-1:0] status, new_evt;
  logic [DW-1:0] word [NWORD];

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  // timeout code: an event overwrites, otherwise per-bit write-one-to-clear
  assign code_clr = (wr && bus_idx == IX_TMO) ? bus_wdata[CODE_LO +: CODE_W] : '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (ev_ilto) code_q <= CODE_ILTO;
    else if (ev_tmo)  code_q <= ev_tmo_code;
    else              code_q <= code_q & ~code_clr;
  end

  // plain read/write control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      en_q   <= '0;
    end else if (wr) begin
      if (bus_idx == IX_CTL) wren_q <= bus_wdata[WREN_BIT];
      if (bus_idx == IX_ENA) en_q   <= bus_wdata[EN_LO +: NCLS];
    end
  end

  // error flags
  always_comb begin
    flg_set.rpt = ev_soft & flg_q.crd;
    flg_set.rds = ev_hard | ev_force;
    flg_set.crd = ev_soft;
    flg_set.frc = ev_force;
    flg_clr = (wr && bus_idx == IX_FLG) ? flags_t'(bus_wdata[FLAG_LO +: 4]) : '0;
  end

  mem_err_sticky #(.W(4)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flg_set), .clr(flg_clr), .q(flg_q));

  mem_err_sticky #(.W(1)) u_inter (
    .clk(clk), .rst_n(rst_n), .set(ev_inter),
    .clr((wr && bus_idx == IX_ENA) ? bus_wdata[INTER_BIT] : 1'b0),
    .q(inter_q));

  // fault latch: [1] fault, [0] non-maskable
  assign flt_set = {ev_hard | ev_force | ev_ilto | ev_inter, ev_force};
  assign flt_clr = (rd && bus_idx == IX_AFLT) ? 2'b11 : 2'b00;
  mem_err_sticky #(.W(2)) u_fault (
    .clk(clk), .rst_n(rst_n), .set(flt_set), .clr(flt_clr), .q(flt_q));
  assign mem_fault = flt_q[1];
  assign nmi_fault = flt_q[0];

  // interrupt
  assign status  = {inter_q[0], code_q == CODE_ILTO, flg_q.crd, flg_q.rds | flg_q.frc};
  assign new_evt = {ev_inter, ev_ilto | (ev_tmo && ev_tmo_code == CODE_ILTO),
                    ev_soft, ev_hard | ev_force};
  mem_err_irq #(.NC(NCLS)) u_irq (
    .clk(clk), .rst_n(rst_n), .status(status), .enable(en_q),
    .new_evt(new_evt), .ack(rd && bus_idx == IX_AIRQ), .irq(mem_irq));

  // read view
  always_comb begin
    for (int i = 0; i < NWORD; i++) word[i] = '0;
    word[IX_TMO][CODE_LO +: CODE_W] = code_q;
    word[IX_CTL][WREN_BIT]          = wren_q;
    word[IX_FLG][FLAG_LO +: 4]      = flg_q;
    word[IX_ENA][EN_LO +: NCLS]     = en_q;
    word[IX_ENA][INTER_BIT]         = inter_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) bus_rdata <= word[bus_idx];
    end
  end

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  p_nmi_implies_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fault |-> mem_fault);
  p_ilto_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ilto |=> (code_q == CODE_ILTO));
endmodule

// File: tb/test_mem_err_csr.sv
`timescale 1ns/100ps
module test_mem_err_csr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [2:0] bus_idx = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic rd_valid;
  logic ev_soft = 0, ev_hard = 0, ev_force = 0, ev_ilto = 0, ev_tmo = 0, ev_inter = 0;
  logic [2:0] ev_tmo_code = 0;
  logic mem_irq, mem_fault, nmi_fault;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  localparam logic [5:0] E_SOFT = 6'h01, E_HARD = 6'h02, E_FORCE = 6'h04,
                         E_ILTO = 6'h08, E_TMO = 6'h10, E_INTER = 6'h20;

  always #2.5 clk = ~clk;

  mem_err_csr i_mem_err_csr (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_valid(rd_valid),
    .ev_soft(ev_soft), .ev_hard(ev_hard), .ev_force(ev_force), .ev_ilto(ev_ilto),
    .ev_tmo(ev_tmo), .ev_tmo_code(ev_tmo_code), .ev_inter(ev_inter),
    .mem_irq(mem_irq), .mem_fault(mem_fault), .nmi_fault(nmi_fault));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock step at a negedge: optional bus access plus event pulses
  task automatic step(input logic en, input logic we, input logic [2:0] idx,
                      input logic [31:0] wd, input logic [5:0] ev, input logic [2:0] code);
    bus_en = en; bus_we = we; bus_idx = idx; bus_wdata = wd;
    ev_soft = ev[0]; ev_hard = ev[1]; ev_force = ev[2];
    ev_ilto = ev[3]; ev_tmo = ev[4]; ev_inter = ev[5]; ev_tmo_code = code;
    @(posedge clk); @(negedge clk);
    if (en && !we) begin
      chk("R2 rd_valid", {31'b0, rd_valid}, 32'd1);
      rv = bus_rdata;
    end
    bus_en = 0; bus_we = 0;
    ev_soft = 0; ev_hard = 0; ev_force = 0; ev_ilto = 0; ev_tmo = 0; ev_inter = 0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    step(1, 1, idx, d, 6'h0, 3'd0);
  endtask
  task automatic rdw(input logic [2:0] idx);
    step(1, 0, idx, 32'h0, 6'h0, 3'd0);
  endtask
  task automatic fire(input logic [5:0] ev, input logic [2:0] code);
    step(0, 0, 3'd0, 32'h0, ev, code);
  endtask
  task automatic clean();
    wr(3'd0, 32'h0700_0000);
    wr(3'd2, 32'hF000_0000);
    wr(3'd3, 32'h0200_0000);
    rdw(3'd5);
    rdw(3'd4);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {29'b0, mem_irq, mem_fault, nmi_fault}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rdw(i[2:0]);
      chk("R1 word", rv, 32'h0);
    end
    // R3 control bit
    wr(3'd1, 32'hFFFF_FFFF); rdw(3'd1); chk("R3 set", rv, 32'h0010_0000);
    wr(3'd1, 32'h0);         rdw(3'd1); chk("R3 clr", rv, 32'h0);
    // R4 enables
    wr(3'd3, 32'hFFFF_FFFF); rdw(3'd3); chk("R4 en", rv, 32'hF000_0000);
    wr(3'd3, 32'h0);         rdw(3'd3); chk("R4 off", rv, 32'h0);
    // R5 timeout code sweep
    for (int c = 0; c < 8; c++) begin
      fire(E_TMO, c[2:0]); rdw(3'd0); chk("R5 code", rv, 32'(c) << 24);
      wr(3'd0, 32'h0700_0000); rdw(3'd0); chk("R5 w1c", rv, 32'h0);
    end
    fire(E_TMO | E_ILTO, 3'd5); rdw(3'd0); chk("R5 ilto prio", rv, 32'h0200_0000);
    fire(E_TMO, 3'd7); wr(3'd0, 32'h0100_0000); rdw(3'd0); chk("R5 bitclr", rv, 32'h0600_0000);
    clean();
    // R6 flags
    fire(E_SOFT, 0); rdw(3'd2); chk("R6 crd", rv, 32'h2000_0000);
    fire(E_SOFT, 0); rdw(3'd2); chk("R6 rpt", rv, 32'hA000_0000);
    fire(E_HARD, 0); rdw(3'd2); chk("R6 rds", rv, 32'hE000_0000);
    wr(3'd2, 32'h0); rdw(3'd2); chk("R6 w0", rv, 32'hE000_0000);
    clean();
    fire(E_FORCE, 0); rdw(3'd2); chk("R6 force", rv, 32'h5000_0000);
    clean();
    for (int m = 0; m < 16; m++) begin
      fire(E_SOFT, 0); fire(E_SOFT | E_FORCE, 0);
      wr(3'd2, 32'(m) << 28); rdw(3'd2);
      chk("R6 mask", rv, 32'((~m) & 15) << 28);
      clean();
    end
    // R7 internal status
    fire(E_INTER, 0); rdw(3'd3); chk("R7 set", rv, 32'h0200_0000);
    wr(3'd3, 32'h0); rdw(3'd3); chk("R7 w0", rv, 32'h0200_0000);
    wr(3'd3, 32'h0200_0000); rdw(3'd3); chk("R7 clr", rv, 32'h0);
    clean();
    // R8 collisions
    fire(E_SOFT, 0);
    step(1, 1, 3'd2, 32'hF000_0000, E_SOFT, 0); rdw(3'd2); chk("R8 flag", rv, 32'hA000_0000);
    step(1, 1, 3'd3, 32'h0200_0000, E_INTER, 0); rdw(3'd3); chk("R8 inter", rv, 32'h0200_0000);
    step(1, 1, 3'd0, 32'h0700_0000, E_ILTO, 0); rdw(3'd0); chk("R8 code", rv, 32'h0200_0000);
    clean();
    // R9 enable x class sweep
    for (int en = 0; en < 16; en++) begin
      for (int cls = 0; cls < 4; cls++) begin
        logic [5:0] ev;
        ev = (cls == 3) ? E_INTER : (cls == 2) ? E_ILTO : (cls == 1) ? E_SOFT : E_HARD;
        wr(3'd3, 32'(en) << 28);
        chk("R9 idle", {31'b0, mem_irq}, 32'd0);
        fire(ev, 0);
        chk("R9 irq", {31'b0, mem_irq}, {31'b0, en[cls]});
        chk("R11 fault", {31'b0, mem_fault}, {31'b0, cls != 1});
        clean();
      end
    end
    // R10 acknowledge
    wr(3'd3, 32'h2000_0000);
    fire(E_SOFT, 0); chk("R10 up", {31'b0, mem_irq}, 32'd1);
    rdw(3'd4); chk("R10 ack", {31'b0, mem_irq}, 32'd0);
    rdw(3'd2); chk("R10 flag kept", rv, 32'h2000_0000);
    fire(E_SOFT, 0); chk("R10 rearm", {31'b0, mem_irq}, 32'd1);
    step(1, 0, 3'd4, 32'h0, E_SOFT, 0); chk("R10 collide", {31'b0, mem_irq}, 32'd1);
    rdw(3'd4); wr(3'd2, 32'hF000_0000); fire(E_SOFT, 0);
    chk("R10 recause", {31'b0, mem_irq}, 32'd1);
    clean();
    // R11 fault latch
    fire(E_FORCE, 0); chk("R11 set", {30'b0, mem_fault, nmi_fault}, 32'd3);
    rdw(3'd5); chk("R11 rd5 val", rv, 32'h0); chk("R11 clr", {30'b0, mem_fault, nmi_fault}, 32'd0);
    fire(E_SOFT, 0); chk("R11 soft", {30'b0, mem_fault, nmi_fault}, 32'd0);
    fire(E_HARD, 0); chk("R11 hard", {30'b0, mem_fault, nmi_fault}, 32'd2);
    step(1, 0, 3'd5, 32'h0, E_HARD, 0); chk("R11 collide", {30'b0, mem_fault, nmi_fault}, 32'd2);
    // R2 strobe words read zero with state present
    fire(E_SOFT | E_INTER, 0);
    for (int i = 4; i < 8; i++) begin
      rdw(i[2:0]); chk("R2 strobe word", rv, 32'h0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule